// File: doc/BRIEF.md
# Cross-Core Cache Line Push Controller

This block moves one cache line from the private L1 of a sending core into the private L1 of a chosen destination core in a small multicore cache model. The sender starts the transfer. No miss is involved. If the sender holds the line modified, ownership leaves the sender and goes with the data. The model keeps, for every core, a direct-mapped L1 with tag, MSI state and line data. It also keeps an inclusive shared L2 directory with a sharer vector, a dirty flag and L2 line data.

A request carries a sender core, a destination core and a line address, and is accepted over a ready/valid handshake. The controller looks up the sender's L1 and makes room in the destination slot if that slot holds a different line. It then copies the line, updates both L1 entries and the directory record, and finishes with a one-cycle done pulse. That pulse is qualified by a moved flag.

An install port places a line and its state in one core's L1 and records it in the directory. A combinational probe port reads any core's L1 entry and the directory record of any address. Together these two ports stand in for refill and for observation.

Top module: `xcore_push`

## Requirements
- R1: `req_ready_o` is high only while the controller is idle. It goes low in the cycle after a request is accepted, and a request held valid while the controller is busy starts no further operation.
- R2: When the sender holds the line Shared (state code 1), the destination L1 receives the tag, the data and state Shared, and the sender stays Shared.
- R3: When the sender holds the line Modified (state code 2), the sender becomes Invalid (code 0), the destination receives the data and state Modified, and the directory shows the destination as the only sharer with the dirty flag set.
- R4: When the sender's L1 does not hold the line, the push changes no L1 entry and no directory record, and `moved_o` is low with the done pulse.
- R5: A push whose destination equals the sender changes nothing. Its done pulse comes two cycles after acceptance with `moved_o` low.
- R6: A push from a Shared sender adds the destination's bit (bit n for core n) to the directory sharer vector and leaves the dirty flag clear.
- R7: If the destination slot (index = low address bits) holds a valid line with a different tag, that line is evicted first. Its sharer bit is cleared in the directory, and a probe of the old address in the destination returns Invalid.
- R8: An evicted Modified line has its data written to L2 and its dirty flag cleared before the slot is overwritten.
- R9: `done_o` is a one-cycle pulse one cycle after the final state write. Counting from the acceptance edge, it appears after 3 cycles for a plain transfer, after 4 with an eviction, and after 2 with no transfer.
- R10: After reset every L1 entry probes Invalid and every directory record has no sharers and a clear dirty flag. A probe whose tag differs from the stored tag reports Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Push request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_src_i | input | CORE_W | Sending core |
| req_dst_i | input | CORE_W | Destination core |
| req_addr_i | input | ADDR_W | Line address |
| done_o | output | 1 | One-cycle completion pulse |
| moved_o | output | 1 | Line was transferred (valid with done_o) |
| inst_valid_i | input | 1 | Install a line into one L1 |
| inst_core_i | input | CORE_W | Core to install into |
| inst_addr_i | input | ADDR_W | Installed line address |
| inst_state_i | input | 2 | Installed state (0 I, 1 S, 2 M) |
| inst_data_i | input | DATA_W | Installed line data |
| prb_core_i | input | CORE_W | Core whose L1 is probed |
| prb_addr_i | input | ADDR_W | Probed line address |
| prb_state_o | output | 2 | Probed L1 state, Invalid on tag mismatch |
| prb_data_o | output | DATA_W | Probed L1 slot data |
| prb_sharers_o | output | NCORES | Directory sharer vector of prb_addr_i |
| prb_dirty_o | output | 1 | Directory dirty flag of prb_addr_i |
| prb_l2_data_o | output | DATA_W | L2 data of prb_addr_i |

## Verification
The assertions assume that installs arrive only while the controller is idle. They also assume that installs keep the model coherent: no Modified line is installed where another core holds it, and no valid line is overwritten by an install without going through a push. The bench keeps to this. Every install is issued between pushes, each install targets an empty slot or repeats a line already shared, and request operands are held stable while valid is high. Under these conditions the ownership and pulse properties must hold on every cycle. The directed scenarios then check the resulting L1 and directory contents through the probe port.

// File: rtl/xpush_pkg.sv
package xpush_pkg;
  typedef enum logic [1:0] {
    MSI_I = 2'd0,
    MSI_S = 2'd1,
    MSI_M = 2'd2
  } msi_e;

  typedef enum logic [1:0] {
    DIR_NOP  = 2'd0,
    DIR_ADD  = 2'd1,
    DIR_OWN  = 2'd2,
    DIR_DROP = 2'd3
  } dir_op_e;
endpackage

// File: rtl/xpush_l1_bank.sv
module xpush_l1_bank
  import xpush_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output msi_e              rd_state_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [IDX_W-1:0]  prb_idx_i,
  output logic [TAG_W-1:0]  prb_tag_o,
  output msi_e              prb_state_o,
  output logic [DATA_W-1:0] prb_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  msi_e              wr_state_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  msi_e              state_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) state_q[i] <= MSI_I;
    end else if (we_i) begin
      state_q[wr_idx_i] <= wr_state_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_state_o  = state_q[rd_idx_i];
  assign rd_data_o   = data_q[rd_idx_i];
  assign prb_tag_o   = tag_q[prb_idx_i];
  assign prb_state_o = state_q[prb_idx_i];
  assign prb_data_o  = data_q[prb_idx_i];
endmodule

// File: rtl/xpush_dir.sv
module xpush_dir
  import xpush_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCORES = 4,
  parameter int DATA_W = 32,
  localparam int CORE_W = $clog2(NCORES),
  localparam int LINES  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dir_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic              wb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] prb_addr_i,
  output logic [NCORES-1:0] prb_sharers_o,
  output logic              prb_dirty_o,
  output logic [DATA_W-1:0] prb_data_o
);
  logic [NCORES-1:0] sharers_q [LINES];
  logic              dirty_q   [LINES];
  logic [DATA_W-1:0] l2_data_q [LINES];
  logic [NCORES-1:0] core_bit;

  assign core_bit = NCORES'(1) << core_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        sharers_q[i] <= '0;
        dirty_q[i]   <= 1'b0;
      end
    end else begin
      unique case (op_i)
        DIR_ADD: sharers_q[addr_i] <= sharers_q[addr_i] | core_bit;
        DIR_OWN: begin
          sharers_q[addr_i] <= core_bit;
          dirty_q[addr_i]   <= 1'b1;
        end
        DIR_DROP: begin
          sharers_q[addr_i] <= sharers_q[addr_i] & ~core_bit;
          if (wb_i) dirty_q[addr_i] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // write-back of a dirty victim lands in L2 data
  always_ff @(posedge clk_i) begin
    if (op_i == DIR_DROP && wb_i) l2_data_q[addr_i] <= data_i;
  end

  assign prb_sharers_o = sharers_q[prb_addr_i];
  assign prb_dirty_o   = dirty_q[prb_addr_i];
  assign prb_data_o    = l2_data_q[prb_addr_i];
endmodule

// File: rtl/xpush_ctrl.sv
module xpush_ctrl
  import xpush_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int CORE_W = 2,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CORE_W-1:0] req_src_i,
  input  logic [CORE_W-1:0] req_dst_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              done_o,
  output logic              moved_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CORE_W-1:0] cur_src_o,
  output logic [CORE_W-1:0] cur_dst_o,
  input  logic [TAG_W-1:0]  src_tag_i,
  input  msi_e              src_state_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic [TAG_W-1:0]  dst_tag_i,
  input  msi_e              dst_state_i,
  input  logic [DATA_W-1:0] dst_data_i,
  output logic              src_we_o,
  output logic              dst_we_o,
  output logic [TAG_W-1:0]  dst_tag_o,
  output msi_e              dst_state_o,
  output logic [DATA_W-1:0] dst_data_o,
  output dir_op_e           dir_op_o,
  output logic [ADDR_W-1:0] dir_addr_o,
  output logic              dir_wb_o,
  output logic [DATA_W-1:0] dir_data_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_EVICT, ST_XFER, ST_DONE} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CORE_W-1:0] src_q, dst_q;
  logic              moved_q;
  logic [TAG_W-1:0]  tag;
  logic              src_hit, dst_conflict;

  assign tag          = addr_q[ADDR_W-1:IDX_W];
  assign src_hit      = (src_state_i != MSI_I) && (src_tag_i == tag);
  assign dst_conflict = (dst_state_i != MSI_I) && (dst_tag_i != tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      moved_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          src_q   <= req_src_i;
          dst_q   <= req_dst_i;
          moved_q <= 1'b0;
          st_q    <= ST_LOOK;
        end
        ST_LOOK: begin
          if (src_q == dst_q || !src_hit) st_q <= ST_DONE;
          else if (dst_conflict)          st_q <= ST_EVICT;
          else                            st_q <= ST_XFER;
        end
        ST_EVICT: st_q <= ST_XFER;
        ST_XFER: begin
          moved_q <= 1'b1;
          st_q    <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    src_we_o    = 1'b0;
    dst_we_o    = 1'b0;
    dst_tag_o   = tag;
    dst_state_o = MSI_I;
    dst_data_o  = src_data_i;
    dir_op_o    = DIR_NOP;
    dir_addr_o  = addr_q;
    dir_wb_o    = 1'b0;
    dir_data_o  = dst_data_i;
    if (st_q == ST_EVICT) begin
      dst_we_o   = 1'b1;
      dst_tag_o  = dst_tag_i;
      dst_data_o = dst_data_i;
      dir_op_o   = DIR_DROP;
      dir_addr_o = {dst_tag_i, addr_q[IDX_W-1:0]};
      dir_wb_o   = (dst_state_i == MSI_M);
    end else if (st_q == ST_XFER) begin
      dst_we_o    = 1'b1;
      dst_state_o = src_state_i;
      if (src_state_i == MSI_M) begin
        src_we_o = 1'b1;
        dir_op_o = DIR_OWN;
      end else begin
        dir_op_o = DIR_ADD;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign moved_o     = done_o & moved_q;
  assign cur_addr_o  = addr_q;
  assign cur_src_o   = src_q;
  assign cur_dst_o   = dst_q;
endmodule

// File: rtl/xcore_push.sv
module xcore_push
  import xpush_pkg::*;
#(
  parameter int NCORES   = 4,
  parameter int L1_LINES = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  localparam int CORE_W  = $clog2(NCORES),
  localparam int IDX_W   = $clog2(L1_LINES),
  localparam int TAG_W   = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CORE_W-1:0] req_src_i,
  input  logic [CORE_W-1:0] req_dst_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              done_o,
  output logic              moved_o,
  input  logic              inst_valid_i,
  input  logic [CORE_W-1:0] inst_core_i,
  input  logic [ADDR_W-1:0] inst_addr_i,
  input  logic [1:0]        inst_state_i,
  input  logic [DATA_W-1:0] inst_data_i,
  input  logic [CORE_W-1:0] prb_core_i,
  input  logic [ADDR_W-1:0] prb_addr_i,
  output logic [1:0]        prb_state_o,
  output logic [DATA_W-1:0] prb_data_o,
  output logic [NCORES-1:0] prb_sharers_o,
  output logic              prb_dirty_o,
  output logic [DATA_W-1:0] prb_l2_data_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic [CORE_W-1:0] cur_src, cur_dst;
  logic              ctl_src_we, ctl_dst_we, ctl_dir_wb;
  logic [TAG_W-1:0]  ctl_dst_tag;
  msi_e              ctl_dst_state, inst_state;
  logic [DATA_W-1:0] ctl_dst_data, ctl_dir_data;
  dir_op_e           ctl_dir_op, dir_op;
  logic [ADDR_W-1:0] ctl_dir_addr;

  logic [TAG_W-1:0]  rd_tag   [NCORES];
  msi_e              rd_state [NCORES];
  logic [DATA_W-1:0] rd_data  [NCORES];
  logic [TAG_W-1:0]  pb_tag   [NCORES];
  msi_e              pb_state [NCORES];
  logic [DATA_W-1:0] pb_data  [NCORES];

  assign inst_state = msi_e'(inst_state_i);

  xpush_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CORE_W(CORE_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_src_i, .req_dst_i,
    .req_addr_i, .done_o, .moved_o,
    .cur_addr_o (cur_addr),
    .cur_src_o  (cur_src),
    .cur_dst_o  (cur_dst),
    .src_tag_i  (rd_tag[cur_src]),
    .src_state_i(rd_state[cur_src]),
    .src_data_i (rd_data[cur_src]),
    .dst_tag_i  (rd_tag[cur_dst]),
    .dst_state_i(rd_state[cur_dst]),
    .dst_data_i (rd_data[cur_dst]),
    .src_we_o   (ctl_src_we),
    .dst_we_o   (ctl_dst_we),
    .dst_tag_o  (ctl_dst_tag),
    .dst_state_o(ctl_dst_state),
    .dst_data_o (ctl_dst_data),
    .dir_op_o   (ctl_dir_op),
    .dir_addr_o (ctl_dir_addr),
    .dir_wb_o   (ctl_dir_wb),
    .dir_data_o (ctl_dir_data)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic              inst_hit, src_hit, dst_hit, we;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    msi_e              wr_state;
    logic [DATA_W-1:0] wr_data;

    assign inst_hit = inst_valid_i && (inst_core_i == CORE_W'(c));
    assign src_hit  = ctl_src_we && (cur_src == CORE_W'(c));
    assign dst_hit  = ctl_dst_we && (cur_dst == CORE_W'(c));
    assign we       = inst_hit | src_hit | dst_hit;

    always_comb begin
      if (inst_hit) begin
        wr_idx   = inst_addr_i[IDX_W-1:0];
        wr_tag   = inst_addr_i[ADDR_W-1:IDX_W];
        wr_state = inst_state;
        wr_data  = inst_data_i;
      end else if (dst_hit) begin
        wr_idx   = cur_addr[IDX_W-1:0];
        wr_tag   = ctl_dst_tag;
        wr_state = ctl_dst_state;
        wr_data  = ctl_dst_data;
      end else begin
        // sender gives up a Modified line
        wr_idx   = cur_addr[IDX_W-1:0];
        wr_tag   = rd_tag[c];
        wr_state = MSI_I;
        wr_data  = rd_data[c];
      end
    end

    xpush_l1_bank #(.LINES(L1_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
      .clk_i, .rst_ni,
      .rd_idx_i   (cur_addr[IDX_W-1:0]),
      .rd_tag_o   (rd_tag[c]),
      .rd_state_o (rd_state[c]),
      .rd_data_o  (rd_data[c]),
      .prb_idx_i  (prb_addr_i[IDX_W-1:0]),
      .prb_tag_o  (pb_tag[c]),
      .prb_state_o(pb_state[c]),
      .prb_data_o (pb_data[c]),
      .we_i       (we),
      .wr_idx_i   (wr_idx),
      .wr_tag_i   (wr_tag),
      .wr_state_i (wr_state),
      .wr_data_i  (wr_data)
    );
  end

  always_comb begin
    dir_op = ctl_dir_op;
    if (inst_valid_i) begin
      unique case (inst_state)
        MSI_M:   dir_op = DIR_OWN;
        MSI_S:   dir_op = DIR_ADD;
        default: dir_op = DIR_NOP;
      endcase
    end
  end

  xpush_dir #(.ADDR_W(ADDR_W), .NCORES(NCORES), .DATA_W(DATA_W)) u_dir (
    .clk_i, .rst_ni,
    .op_i         (dir_op),
    .addr_i       (inst_valid_i ? inst_addr_i : ctl_dir_addr),
    .core_i       (inst_valid_i ? inst_core_i : cur_dst),
    .wb_i         (!inst_valid_i && ctl_dir_wb),
    .data_i       (ctl_dir_data),
    .prb_addr_i,
    .prb_sharers_o,
    .prb_dirty_o,
    .prb_data_o   (prb_l2_data_o)
  );

  assign prb_state_o = (pb_tag[prb_core_i] == prb_addr_i[ADDR_W-1:IDX_W])
                     ? pb_state[prb_core_i] : MSI_I;
  assign prb_data_o  = pb_data[prb_core_i];
endmodule

// File: rtl/xpush_chk.sv
module xpush_chk
  import xpush_pkg::*;
#(
  parameter int CORE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [CORE_W-1:0] req_src_i,
  input logic [CORE_W-1:0] req_dst_i,
  input logic              done_o,
  input logic              moved_o,
  input logic              ctl_src_we,
  input logic              ctl_dst_we,
  input dir_op_e           dir_op
);
  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  a_r9_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && moved_o |-> $past(ctl_dst_we));

  a_r5_self_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_src_i == req_dst_i |=> ##1 (done_o && !moved_o));

  a_r3_owner_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_src_we |-> ctl_dst_we && dir_op == DIR_OWN);
endmodule

bind xcore_push xpush_chk #(.CORE_W(CORE_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_src_i, .req_dst_i,
  .done_o, .moved_o, .ctl_src_we, .ctl_dst_we, .dir_op
);

// File: tb/xcore_push_tb_top.sv
module xcore_push_tb_top;
  localparam int NC = 4, AW = 8, DW = 32, CW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [CW-1:0] req_src = '0, req_dst = '0;
  logic [AW-1:0] req_addr = '0;
  logic done, moved;
  logic inst_valid = 1'b0;
  logic [CW-1:0] inst_core = '0;
  logic [AW-1:0] inst_addr = '0;
  logic [1:0] inst_state = '0;
  logic [DW-1:0] inst_data = '0;
  logic [CW-1:0] prb_core = '0;
  logic [AW-1:0] prb_addr = '0;
  logic [1:0] prb_state;
  logic [DW-1:0] prb_data, prb_l2;
  logic [NC-1:0] prb_sharers;
  logic prb_dirty;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xcore_push dut_i (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_src_i(req_src), .req_dst_i(req_dst), .req_addr_i(req_addr),
    .done_o(done), .moved_o(moved), .inst_valid_i(inst_valid),
    .inst_core_i(inst_core), .inst_addr_i(inst_addr), .inst_state_i(inst_state),
    .inst_data_i(inst_data), .prb_core_i(prb_core), .prb_addr_i(prb_addr),
    .prb_state_o(prb_state), .prb_data_o(prb_data), .prb_sharers_o(prb_sharers),
    .prb_dirty_o(prb_dirty), .prb_l2_data_o(prb_l2)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic install(int c, int a, int st, logic [DW-1:0] d);
    @(negedge clk);
    inst_valid = 1'b1; inst_core = CW'(c); inst_addr = AW'(a);
    inst_state = 2'(st); inst_data = d;
    @(negedge clk);
    inst_valid = 1'b0;
  endtask

  task automatic probe(string req, int c, int a, int st, logic [DW-1:0] d, int sh, bit dirty);
    prb_core = CW'(c); prb_addr = AW'(a);
    #1;
    chk(req, prb_state, 64'(st));
    if (st != 0) chk(req, prb_data, d);
    chk(req, prb_sharers, 64'(sh));
    chk(req, prb_dirty, dirty);
  endtask

  // push and measure done latency from the acceptance edge
  task automatic push(string req, int s, int d, int a, int lat, bit mv);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_src = CW'(s); req_dst = CW'(d); req_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk({req, "/R1 ready low"}, req_ready, 0);
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk({req, "/R9 latency"}, n, lat);
    chk({req, " moved"}, moved, mv);
    @(negedge clk);
    chk({req, "/R9 pulse"}, done, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset ready", req_ready, 1);
    chk("R9 reset done", done, 0);
    probe("R10 reset", 2, 8'h25, 0, '0, 0, 0);
  endtask

  task automatic t_shared();
    install(0, 8'h25, 1, 32'hA1A1_0001);
    push("R2 shared", 0, 2, 8'h25, 3, 1);
    probe("R2 dst", 2, 8'h25, 1, 32'hA1A1_0001, 4'b0101, 0);
    probe("R6 src", 0, 8'h25, 1, 32'hA1A1_0001, 4'b0101, 0);
  endtask

  task automatic t_modified();
    install(1, 8'h47, 2, 32'hB2B2_0002);
    push("R3 modified", 1, 3, 8'h47, 3, 1);
    probe("R3 src", 1, 8'h47, 0, '0, 4'b1000, 1);
    probe("R3 dst", 3, 8'h47, 2, 32'hB2B2_0002, 4'b1000, 1);
  endtask

  task automatic t_invalid();
    push("R4 invalid", 0, 1, 8'h99, 2, 0);
    probe("R4 dst", 1, 8'h99, 0, '0, 0, 0);
  endtask

  task automatic t_self();
    push("R5 self", 3, 3, 8'h47, 2, 0);
    probe("R5 state", 3, 8'h47, 2, 32'hB2B2_0002, 4'b1000, 1);
  endtask

  task automatic t_clean_evict();
    install(1, 8'h35, 1, 32'hC3C3_0003);
    push("R7 clean evict", 1, 2, 8'h35, 4, 1);
    probe("R7 old", 2, 8'h25, 0, '0, 4'b0001, 0);
    probe("R7 new", 2, 8'h35, 1, 32'hC3C3_0003, 4'b0110, 0);
  endtask

  task automatic t_dirty_evict();
    install(0, 8'h17, 1, 32'hD4D4_0004);
    push("R8 dirty evict", 0, 3, 8'h17, 4, 1);
    probe("R8 old", 3, 8'h47, 0, '0, 0, 0);
    chk("R8 l2 data", prb_l2, 32'hB2B2_0002);
    probe("R8 new", 3, 8'h17, 1, 32'hD4D4_0004, 4'b1001, 0);
  endtask

  // valid held through the whole operation: exactly one done pulse
  task automatic t_busy();
    int pulses = 0;
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'd2; req_dst = 2'd0; req_addr = 8'h35;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) begin
        pulses++;
        req_valid = 1'b0;
      end
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk("R1 one op while busy", pulses, 1);
    probe("R1 result", 0, 8'h35, 1, 32'hC3C3_0003, 4'b0111, 0);
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared();
    t_modified();
    t_invalid();
    t_self();
    t_clean_evict();
    t_dirty_evict();
    t_busy();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule